// File: doc/BRIEF.md
# Registered 32-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small datapath. Each cycle it takes two 32-bit operands, a carry-in bit, a 5-bit shift count and a 3-bit operation code. It computes one of seven functions: add with carry, subtract, logical shift right, logical shift left, bitwise NAND, signed minimum and signed set-less-than.

Alongside the 32-bit result it raises four flags. The first marks signed overflow of an add. The second marks operands that are equal. The third marks a zero result, and the fourth copies the result's sign bit. The result and the flags go out through one output register stage, so a value presented at a rising edge appears on the outputs for the following cycle.

The surrounding datapath picks the operands and decides where the result goes. This block only computes and registers it.

Top module: `alu_core32`

## Requirements
- R1: Op code 000 yields `a_i + b_i + cin_i`, truncated to 32 bits.
- R2: Op code 001 yields `a_i - b_i` in two's complement, and `cin_i` has no effect on it.
- R3: Op code 010 shifts `a_i` right by `shamt_i` and op code 011 shifts it left by `shamt_i`. Vacated bit positions are filled with 0.
- R4: Op code 101 yields the bitwise NAND of `a_i` and `b_i`.
- R5: Op code 110 yields the smaller of `a_i` and `b_i`, both read as signed numbers.
- R6: Op code 111 yields 1 when `a_i < b_i` as signed numbers and 0 otherwise. Bits 31..1 are always 0.
- R7: `ovf_o` is 1 only when the op code was 000 and the signed sum overflowed. For example, 2^30 + 2^30 sets it and gives a negative result.
- R8: `eq_o` is 1 exactly when `a_i` equals `b_i`, whatever the op code.
- R9: `zero_o` is 1 exactly when `res_o` is 0, and `neg_o` always equals bit 31 of `res_o`.
- R10: Op code 100 yields a result of 0. In that case `zero_o` is 1 and `neg_o` and `ovf_o` are 0.
- R11: While `rst` is high at a rising edge, the outputs are set to `res_o` = 0, `zero_o` = 1 and all other flags 0. Otherwise, the inputs sampled at a rising edge appear on all outputs after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| cin_i | input | 1 | Carry-in for add |
| shamt_i | input | 5 | Shift count |
| res_o | output | 32 | Registered result |
| ovf_o | output | 1 | Add signed overflow |
| eq_o | output | 1 | Operands equal |
| zero_o | output | 1 | Result is zero |
| neg_o | output | 1 | Result sign bit |

## Verification
Every output has a latency of exactly one rising edge. The result and all four flags for inputs driven before edge n are valid between edge n and edge n+1.

The bench drives inputs on falling edges and pushes the reference model's prediction into a queue. On the next falling edge, after the single register stage has loaded, it pops that prediction and compares it with the outputs. The reset values are checked on falling edges while `rst` is high, including one cycle in which the inputs change under reset.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_SRL  = 3'b010,
    OP_SLL  = 3'b011,
    OP_NONE = 3'b100,
    OP_NAND = 3'b101,
    OP_MIN  = 3'b110,
    OP_SLT  = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic ovf;
    logic eq;
    logic zero;
    logic neg;
  } alu_flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         do_sub,
  output logic [W-1:0] sum,
  output logic         ovf
);

  logic [W-1:0] b_eff;
  logic [W-1:0] c_ext;

  // Subtract reuses the adder: invert b and force carry-in to 1.
  always_comb begin
    b_eff = do_sub ? ~b : b;
    c_ext = '0;
    c_ext[0] = do_sub ? 1'b1 : cin;
    sum = a + b_eff + c_ext;
    ovf = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  end

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W  = 32,
  parameter int SW = 5
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          left,
  output logic [W-1:0]  dout
);

  logic [W-1:0] rev_in;
  logic [W-1:0] rev_out;
  logic [W-1:0] stage [0:SW];

  // Left shifts reuse the right shifter by mirroring input and output.
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = din[W-1-i];
    assign rev_out[i] = stage[SW][W-1-i];
  end

  assign stage[0] = left ? rev_in : din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    assign stage[k+1] = amt[k] ? (stage[k] >> (1 << k)) : stage[k];
  end

  assign dout = left ? rev_out : stage[SW];

endmodule

// File: rtl/alu_cmp.sv
module alu_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq,
  output logic         lt
);

  always_comb begin
    eq = (a == b);
    lt = ($signed(a) < $signed(b));
  end

endmodule

// File: rtl/alu_core32.sv
module alu_core32 #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         op_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic               cin_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic [DATA_W-1:0]  res_o,
  output logic               ovf_o,
  output logic               eq_o,
  output logic               zero_o,
  output logic               neg_o
);
  import alu_pkg::*;

  localparam int MSB = DATA_W - 1;

  alu_op_e      op;
  logic [MSB:0] sum, shv, res_d;
  logic         add_ovf, is_eq, is_lt;
  alu_flags_t   flg_d;

  assign op = alu_op_e'(op_i);

  alu_addsub #(.W(DATA_W)) u_add (
    .a(a_i), .b(b_i), .cin(cin_i), .do_sub(op == OP_SUB),
    .sum(sum), .ovf(add_ovf)
  );

  alu_shift #(.W(DATA_W), .SW(SHAMT_W)) u_shf (
    .din(a_i), .amt(shamt_i), .left(op_i[0]), .dout(shv)
  );

  alu_cmp #(.W(DATA_W)) u_cmp (
    .a(a_i), .b(b_i), .eq(is_eq), .lt(is_lt)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: res_d = sum;
      OP_SRL, OP_SLL: res_d = shv;
      OP_NAND:        res_d = ~(a_i & b_i);
      OP_MIN:         res_d = is_lt ? a_i : b_i;
      OP_SLT:         res_d = {{MSB{1'b0}}, is_lt};
      default:        res_d = '0;
    endcase
    flg_d.ovf  = (op == OP_ADD) && add_ovf;
    flg_d.eq   = is_eq;
    flg_d.zero = (res_d == '0);
    flg_d.neg  = res_d[MSB];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o  <= '0;
      ovf_o  <= 1'b0;
      eq_o   <= 1'b0;
      zero_o <= 1'b1;
      neg_o  <= 1'b0;
    end else begin
      res_o  <= res_d;
      ovf_o  <= flg_d.ovf;
      eq_o   <= flg_d.eq;
      zero_o <= flg_d.zero;
      neg_o  <= flg_d.neg;
    end
  end

endmodule

// File: rtl/alu_core32_chk.sv
module alu_core32_chk #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input logic               clk,
  input logic               rst,
  input logic [2:0]         op_i,
  input logic [DATA_W-1:0]  a_i,
  input logic [DATA_W-1:0]  b_i,
  input logic               cin_i,
  input logic [SHAMT_W-1:0] shamt_i,
  input logic [DATA_W-1:0]  res_o,
  input logic               ovf_o,
  input logic               eq_o,
  input logic               zero_o,
  input logic               neg_o
);

  logic live = 1'b0;
  always_ff @(posedge clk) live <= !rst;

  // R7
  ovf_only_add_chk: assert property (@(posedge clk) disable iff (rst || !live)
    ovf_o |-> ($past(op_i) == 3'b000));

  // R8
  eq_flag_chk: assert property (@(posedge clk) disable iff (rst || !live)
    eq_o == ($past(a_i) == $past(b_i)));

  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    zero_o == (res_o == '0));

  // R9
  sign_flag_chk: assert property (@(posedge clk) disable iff (rst)
    neg_o == res_o[DATA_W-1]);

  // R6
  slt_range_chk: assert property (@(posedge clk) disable iff (rst || !live)
    ($past(op_i) == 3'b111) |-> (res_o[DATA_W-1:1] == '0));

  // R10
  unused_op_chk: assert property (@(posedge clk) disable iff (rst || !live)
    ($past(op_i) == 3'b100) |-> (res_o == '0));

  // R2
  sub_result_chk: assert property (@(posedge clk) disable iff (rst || !live)
    ($past(op_i) == 3'b001) |-> (res_o == $past(a_i) - $past(b_i)));

endmodule

bind alu_core32 alu_core32_chk #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
  .shamt_i(shamt_i), .res_o(res_o), .ovf_o(ovf_o), .eq_o(eq_o),
  .zero_o(zero_o), .neg_o(neg_o)
);

// File: tb/sim_alu_core32.sv
`timescale 1ns/1ps
module sim_alu_core32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic        cin = 1'b0;
  logic [4:0]  sh = '0;
  logic [31:0] res;
  logic        ovf, eq, zero, neg;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    logic [2:0]  op;
    logic [31:0] res;
    logic        ovf, eq, zero, neg;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  alu_core32 u0 (
    .clk(clk), .rst(rst), .op_i(op), .a_i(a), .b_i(b), .cin_i(cin),
    .shamt_i(sh), .res_o(res), .ovf_o(ovf), .eq_o(eq), .zero_o(zero), .neg_o(neg)
  );

  function automatic exp_t model(logic [2:0] o, logic [31:0] x, logic [31:0] y,
                                 logic c, logic [4:0] s);
    exp_t e;
    longint sx = longint'($signed(x));
    longint sy = longint'($signed(y));
    longint t;
    e.op = o;
    e.ovf = 1'b0;
    case (o)
      3'd0: begin
        t = sx + sy + longint'(c);
        e.res = t[31:0];
        e.ovf = (t > 64'sd2147483647) || (t < -64'sd2147483648);
      end
      3'd1: begin t = sx - sy; e.res = t[31:0]; end
      3'd2: e.res = x >> s;
      3'd3: e.res = x << s;
      3'd5: e.res = ~(x & y);
      3'd6: e.res = (sx < sy) ? x : y;
      3'd7: e.res = (sx < sy) ? 32'd1 : 32'd0;
      default: e.res = 32'd0;
    endcase
    e.eq = (x == y);
    e.zero = (e.res == 32'd0);
    e.neg = e.res[31];
    return e;
  endfunction

  function automatic string op_tag(logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd5: return "R4";
      3'd6: return "R5";
      3'd7: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_pending();
    exp_t e;
    if (q.size() == 0) return;
    e = q.pop_front();
    chk(op_tag(e.op), "result", res, e.res);
    chk("R7", "ovf", {31'd0, ovf}, {31'd0, e.ovf});
    chk("R8", "eq", {31'd0, eq}, {31'd0, e.eq});
    chk("R9", "zero", {31'd0, zero}, {31'd0, e.zero});
    chk("R9", "sgn", {31'd0, neg}, {31'd0, e.neg});
  endtask

  task automatic step(logic [2:0] o, logic [31:0] x, logic [31:0] y,
                      logic c, logic [4:0] s);
    @(negedge clk);
    compare_pending();
    op = o; a = x; b = y; cin = c; sh = s;
    q.push_back(model(o, x, y, c, s));
  endtask

  task automatic check_reset_state();
    chk("R11", "reset res", res, 32'd0);
    chk("R11", "reset flags", {28'd0, ovf, eq, zero, neg}, 32'b0010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();
    op = 3'd0; a = 32'd7; b = 32'd7; cin = 1'b1; sh = 5'd3;
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    // directed program-like sequence
    step(3'd0, 32'd4, 32'd10, 1'b1, 5'd0);            // R1 15
    step(3'd1, 32'd15, 32'd4, 1'b1, 5'd0);            // R2 cin ignored
    step(3'd7, 32'd11, 32'd15, 1'b0, 5'd0);           // R6
    step(3'd7, 32'd15, 32'd11, 1'b0, 5'd0);           // R6 zero
    step(3'd3, 32'd1, 32'd0, 1'b0, 5'd3);             // R3 left
    step(3'd2, 32'd8, 32'd0, 1'b0, 5'd2);             // R3 right
    step(3'd2, 32'h8000_0000, 32'd0, 1'b0, 5'd31);    // R3 zero-fill
    step(3'd3, 32'hFFFF_FFFF, 32'd0, 1'b0, 5'd31);    // R3
    step(3'd5, 32'd8, 32'd2, 1'b0, 5'd0);             // R4 -1
    step(3'd6, 32'd2, 32'hFFFF_FFFF, 1'b0, 5'd0);     // R5 -1
    step(3'd6, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 5'd0); // R5 signed
    step(3'd0, 32'h4000_0000, 32'h4000_0000, 1'b0, 5'd0); // R7 overflow
    step(3'd1, 32'h4000_0000, 32'h4000_0000, 1'b1, 5'd0); // R8 R9 zero
    step(3'd1, 32'h8000_0000, 32'd1, 1'b0, 5'd0);     // R7 no ovf on sub
    step(3'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 5'd0); // R7 with cin
    step(3'd0, 32'h8000_0000, 32'h8000_0000, 1'b1, 5'd0); // R7 negative
    step(3'd4, 32'hDEAD_BEEF, 32'h1234, 1'b1, 5'd7);  // R10
    step(3'd4, 32'h55, 32'h55, 1'b0, 5'd1);           // R10 eq still
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom();
      rb = (i % 7 == 0) ? ra : $urandom();
      if (i % 11 == 0) ra = {$urandom_range(1, 0) == 1 ? 1'b1 : 1'b0, 31'h7FFF_FFF0};
      step(3'($urandom_range(7, 0)), ra, rb, 1'($urandom_range(1, 0)),
           5'($urandom_range(31, 0)));
    end
    @(negedge clk);
    compare_pending();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R11 watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule